// File: doc/BRIEF.md
# Write-Once Mode Security Register File

This block is the control and status register file of a small secure device. A CPU reaches it over a simple word-addressed bus. The bus has a chip select, a write enable, 32-bit write data and a registered 32-bit read port. The block returns fixed identity words. It holds the LED and GPIO controls, the application start, size and function-pointer words, a 256-bit secret, and two write-only keys that feed the RAM scrambler.

A single mode bit separates firmware operation from application operation. Firmware sets it once, and only while the firmware-mode flag is high. After that the bit cannot be cleared. Setting it freezes the application words, the function pointer, the secret and both scramble keys. The secret becomes readable only after this point.

The block also watches a CPU trap line. Once the trap line is seen high, the LED pins show a blinking red pattern until the next reset, whatever the LED register holds.

Top module: `secure_cfg_regs`

## Requirements
- R1: Reads of word addresses 0x00 and 0x01 return the two name constants (NAME_HI, NAME_LO), and a read of 0x02 returns the VERSION constant. Writes to these addresses change nothing.
- R2: A write to 0x08 with wdata bit 0 set, made while fw_mode is high, sets the mode bit. The mode bit drives app_mode and reads back as bit 0 of word 0x08.
- R3: Once set, the mode bit stays set until reset. A write to 0x08 made while fw_mode is low has no effect.
- R4: Word 0x09 holds the LED bits: bit 0 blue, bit 1 green, bit 2 red, with 1 meaning on. The word can be read and written in either mode. With no trap seen, led[2:0] equals this word.
- R5: At word 0x0a, bits 3:2 are held and drive gpio_out[1:0]. Bits 1:0 read gpio_in[1:0] through a two-flop synchronizer, and writes to bits 1:0 are ignored.
- R6: Words 0x0c (application start), 0x0d (application size) and 0x10 (function pointer) are readable at all times. They accept writes only while the mode bit is clear.
- R7: The eight secret words at 0x20 to 0x27 accept writes only while the mode bit is clear. Reads return zero while the mode bit is clear and the stored word once it is set.
- R8: Words 0x30 (low half) and 0x31 (high half) return the 64-bit UID constant. Writes to them are ignored.
- R9: Writes to 0x40 and 0x41 load addr_key and data_key. Both words read as zero. Once the mode bit is set, writes to them are ignored.
- R10: From the cycle after cpu_trap is sampled high, and until reset, led[1:0] is 0. led[2] equals bit BLINK_LOG2 of a free-running cycle counter that is cleared by reset, so it toggles every 2^BLINK_LOG2 cycles.
- R11: rdata is registered. It carries the addressed word in the cycle after a read (cs high, we low) and is zero otherwise. Unmapped addresses read as zero.
- R12: After reset, every held register, led, gpio_out, both keys, app_mode and rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Bus access strobe |
| we | input | 1 | Write when high, read when low |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| fw_mode | input | 1 | High while firmware runs |
| gpio_in | input | 2 | Asynchronous GPIO input pins |
| cpu_trap | input | 1 | CPU trap indication |
| led | output | 3 | RGB LED drive {red, green, blue} |
| gpio_out | output | 2 | GPIO output pins |
| addr_key | output | 32 | Address scramble key |
| data_key | output | 32 | Data scramble key |
| app_mode | output | 1 | Mode bit, high in application mode |

## Verification
The assertions check on every cycle that:
- the mode bit never falls and only rises after a write made in firmware mode;
- the scramble keys never move once the mode bit is set;
- the GPIO outputs hold without a write;
- rdata is zero after a cycle without a read;
- a trap clears the blue and green LED drive.

Some properties depend on address decode and stored values, so only the bench's scenarios can show them. These are the read-back of each word, the hidden secret before the switch, the rejected writes after it, and the two-flop GPIO input delay. The bench also checks the blink period against its reference model.

// File: rtl/secregs_pkg.sv
package secregs_pkg;

    localparam int WORD_W       = 32;
    localparam int SECRET_WORDS = 8;
    localparam int SECRET_IDX_W = $clog2(SECRET_WORDS);

    // Word addresses; the secret base is aligned so its low bits index the word
    localparam logic [7:0] A_NAME_HI = 8'h00;
    localparam logic [7:0] A_NAME_LO = 8'h01;
    localparam logic [7:0] A_VERSION = 8'h02;
    localparam logic [7:0] A_MODE    = 8'h08;
    localparam logic [7:0] A_LED     = 8'h09;
    localparam logic [7:0] A_GPIO    = 8'h0a;
    localparam logic [7:0] A_START   = 8'h0c;
    localparam logic [7:0] A_SIZE    = 8'h0d;
    localparam logic [7:0] A_FNPTR   = 8'h10;
    localparam logic [7:0] A_SECRET  = 8'h20;
    localparam logic [7:0] A_UID_LO  = 8'h30;
    localparam logic [7:0] A_UID_HI  = 8'h31;
    localparam logic [7:0] A_AKEY    = 8'h40;
    localparam logic [7:0] A_DKEY    = 8'h41;

    typedef struct packed {
        logic                                     app_mode;
        logic [2:0]                               led;
        logic [1:0]                               gpo;
        logic [WORD_W-1:0]                        app_start;
        logic [WORD_W-1:0]                        app_size;
        logic [WORD_W-1:0]                        fn_ptr;
        logic [SECRET_WORDS-1:0][WORD_W-1:0]      secret;
        logic [WORD_W-1:0]                        akey;
        logic [WORD_W-1:0]                        dkey;
        logic [WORD_W-1:0]                        rdata;
    } regs_t;

endpackage

// File: rtl/secregs_sync.sv
module secregs_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/secregs_blink.sv
module secregs_blink #(
    parameter int BLINK_LOG2 = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_trap,
    input  logic [2:0] led_reg,
    output logic [2:0] led_out
);
    localparam int CNT_W = BLINK_LOG2 + 1;

    typedef struct packed {
        logic             trapped;
        logic [CNT_W-1:0] cnt;
    } blink_t;

    blink_t bl_d, bl_q;

    always_comb begin
        bl_d     = bl_q;
        bl_d.cnt = bl_q.cnt + CNT_W'(1);
        if (cpu_trap) bl_d.trapped = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bl_q <= '0;
        else        bl_q <= bl_d;
    end

    assign led_out = bl_q.trapped ? {bl_q.cnt[CNT_W-1], 2'b00} : led_reg;
endmodule

// File: rtl/secregs_rdmux.sv
module secregs_rdmux
    import secregs_pkg::*;
#(
    parameter int              ADDR_W  = 8,
    parameter logic [31:0]     NAME_HI = 32'h0,
    parameter logic [31:0]     NAME_LO = 32'h0,
    parameter logic [31:0]     VERSION = 32'h0,
    parameter logic [63:0]     UID     = 64'h0
) (
    input  logic [ADDR_W-1:0]                    addr,
    input  logic                                 app_mode,
    input  logic [2:0]                           led,
    input  logic [1:0]                           gpo,
    input  logic [1:0]                           gpi,
    input  logic [WORD_W-1:0]                    app_start,
    input  logic [WORD_W-1:0]                    app_size,
    input  logic [WORD_W-1:0]                    fn_ptr,
    input  logic [SECRET_WORDS-1:0][WORD_W-1:0]  secret,
    output logic [WORD_W-1:0]                    word
);
    localparam int HI_W = ADDR_W - SECRET_IDX_W;

    logic in_secret;
    assign in_secret = (addr[ADDR_W-1:SECRET_IDX_W] ==
                        HI_W'(A_SECRET >> SECRET_IDX_W));

    always_comb begin
        word = '0;
        if (in_secret) begin
            if (app_mode) word = secret[addr[SECRET_IDX_W-1:0]];
        end else begin
            case (addr)
                ADDR_W'(A_NAME_HI): word = NAME_HI;
                ADDR_W'(A_NAME_LO): word = NAME_LO;
                ADDR_W'(A_VERSION): word = VERSION;
                ADDR_W'(A_MODE):    word = {31'd0, app_mode};
                ADDR_W'(A_LED):     word = {29'd0, led};
                ADDR_W'(A_GPIO):    word = {28'd0, gpo, gpi};
                ADDR_W'(A_START):   word = app_start;
                ADDR_W'(A_SIZE):    word = app_size;
                ADDR_W'(A_FNPTR):   word = fn_ptr;
                ADDR_W'(A_UID_LO):  word = UID[31:0];
                ADDR_W'(A_UID_HI):  word = UID[63:32];
                default:            word = '0;
            endcase
        end
    end
endmodule

// File: rtl/secure_cfg_regs.sv
module secure_cfg_regs
    import secregs_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          BLINK_LOG2 = 3,
    parameter logic [31:0] NAME_HI    = 32'h7365_6372,
    parameter logic [31:0] NAME_LO    = 32'h6b65_7931,
    parameter logic [31:0] VERSION    = 32'h0000_0005,
    parameter logic [63:0] UID        = 64'h0123_4567_89ab_cdef
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              fw_mode,
    input  logic [1:0]        gpio_in,
    input  logic              cpu_trap,
    output logic [2:0]        led,
    output logic [1:0]        gpio_out,
    output logic [31:0]       addr_key,
    output logic [31:0]       data_key,
    output logic              app_mode
);
    regs_t r_d, r_q;

    logic [1:0]        gpi_sync;
    logic [WORD_W-1:0] rd_word;
    logic              wr_en, rd_en, unlocked;

    assign wr_en    = cs &  we;
    assign rd_en    = cs & ~we;
    assign unlocked = ~r_q.app_mode;

    secregs_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gpio_in),
        .q     (gpi_sync)
    );

    secregs_rdmux #(
        .ADDR_W  (ADDR_W),
        .NAME_HI (NAME_HI),
        .NAME_LO (NAME_LO),
        .VERSION (VERSION),
        .UID     (UID)
    ) u_rdmux (
        .addr      (addr),
        .app_mode  (r_q.app_mode),
        .led       (r_q.led),
        .gpo       (r_q.gpo),
        .gpi       (gpi_sync),
        .app_start (r_q.app_start),
        .app_size  (r_q.app_size),
        .fn_ptr    (r_q.fn_ptr),
        .secret    (r_q.secret),
        .word      (rd_word)
    );

    secregs_blink #(.BLINK_LOG2(BLINK_LOG2)) u_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_trap (cpu_trap),
        .led_reg  (r_q.led),
        .led_out  (led)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rdata = rd_en ? rd_word : '0;
        if (wr_en) begin
            case (addr)
                ADDR_W'(A_MODE):  if (fw_mode && wdata[0]) r_d.app_mode = 1'b1;
                ADDR_W'(A_LED):   r_d.led = wdata[2:0];
                ADDR_W'(A_GPIO):  r_d.gpo = wdata[3:2];
                ADDR_W'(A_START): if (unlocked) r_d.app_start = wdata;
                ADDR_W'(A_SIZE):  if (unlocked) r_d.app_size  = wdata;
                ADDR_W'(A_FNPTR): if (unlocked) r_d.fn_ptr    = wdata;
                ADDR_W'(A_AKEY):  if (unlocked) r_d.akey      = wdata;
                ADDR_W'(A_DKEY):  if (unlocked) r_d.dkey      = wdata;
                default: ;
            endcase
            for (int i = 0; i < SECRET_WORDS; i++) begin
                if (unlocked && addr == ADDR_W'(A_SECRET) + ADDR_W'(i))
                    r_d.secret[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata    = r_q.rdata;
    assign gpio_out = r_q.gpo;
    assign addr_key = r_q.akey;
    assign data_key = r_q.dkey;
    assign app_mode = r_q.app_mode;
endmodule

// File: rtl/secregs_chk.sv
module secregs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs,
    input logic        we,
    input logic        fw_mode,
    input logic        cpu_trap,
    input logic [31:0] rdata,
    input logic [2:0]  led,
    input logic [1:0]  gpio_out,
    input logic [31:0] addr_key,
    input logic [31:0] data_key,
    input logic        app_mode
);
    assert_mode_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        app_mode |=> app_mode);

    assert_mode_needs_fw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(app_mode) |-> $past(fw_mode && cs && we));

    assert_keys_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        app_mode |=> ($stable(addr_key) && $stable(data_key)));

    assert_trap_red_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_trap |=> (led[1:0] == 2'b00));

    assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && !we) |=> (rdata == 32'd0));

    assert_gpo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && we) |=> $stable(gpio_out));
endmodule

bind secure_cfg_regs secregs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .we       (we),
    .fw_mode  (fw_mode),
    .cpu_trap (cpu_trap),
    .rdata    (rdata),
    .led      (led),
    .gpio_out (gpio_out),
    .addr_key (addr_key),
    .data_key (data_key),
    .app_mode (app_mode)
);

// File: tb/test_secure_cfg_regs.sv
module test_secure_cfg_regs;
    localparam int          AW    = 8;
    localparam int          BL    = 3;
    localparam logic [31:0] N_HI  = 32'h7365_6372;
    localparam logic [31:0] N_LO  = 32'h6b65_7931;
    localparam logic [31:0] VER   = 32'h0000_0005;
    localparam logic [63:0] UIDV  = 64'h0123_4567_89ab_cdef;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs = 1'b0, we = 1'b0, fw_mode = 1'b0, cpu_trap = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [1:0]    gpio_in = '0;
    logic [31:0]   rdata, addr_key, data_key;
    logic [2:0]    led;
    logic [1:0]    gpio_out;
    logic          app_mode;

    always #10 clk = ~clk;

    secure_cfg_regs #(
        .ADDR_W(AW), .BLINK_LOG2(BL), .NAME_HI(N_HI), .NAME_LO(N_LO),
        .VERSION(VER), .UID(UIDV)
    ) i_secure_cfg_regs (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .fw_mode(fw_mode), .gpio_in(gpio_in), .cpu_trap(cpu_trap),
        .led(led), .gpio_out(gpio_out), .addr_key(addr_key), .data_key(data_key),
        .app_mode(app_mode)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // behavioural reference model
    logic        m_mode, m_trap, m_s1_0, m_s1_1, m_s2_0, m_s2_1;
    logic [2:0]  m_led;
    logic [1:0]  m_gpo;
    int          m_start, m_size, m_fn, m_ak, m_dk, m_cnt;
    int          m_sec[8];
    logic [31:0] m_rd;

    function automatic logic [31:0] model_read(int a);
        if (a >= 32 && a < 40) return m_mode ? m_sec[a-32] : 32'd0;
        case (a)
            0:  return N_HI;
            1:  return N_LO;
            2:  return VER;
            8:  return {31'd0, m_mode};
            9:  return {29'd0, m_led};
            10: return {28'd0, m_gpo, m_s2_1, m_s2_0};
            12: return m_start;
            13: return m_size;
            16: return m_fn;
            48: return UIDV[31:0];
            49: return UIDV[63:32];
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_trap = 0; m_led = 0; m_gpo = 0; m_rd = 0;
            m_start = 0; m_size = 0; m_fn = 0; m_ak = 0; m_dk = 0; m_cnt = 0;
            m_s1_0 = 0; m_s1_1 = 0; m_s2_0 = 0; m_s2_1 = 0;
            foreach (m_sec[i]) m_sec[i] = 0;
        end else begin
            int a;
            a = int'(addr);
            m_rd = (cs && !we) ? model_read(a) : 32'd0;
            if (cs && we) begin
                if (a == 8 && fw_mode && wdata[0]) m_mode = 1;
                else if (a == 9)  m_led = wdata[2:0];
                else if (a == 10) m_gpo = wdata[3:2];
                else if (!m_mode) begin
                    if (a == 12) m_start = wdata;
                    if (a == 13) m_size  = wdata;
                    if (a == 16) m_fn    = wdata;
                    if (a == 64) m_ak    = wdata;
                    if (a == 65) m_dk    = wdata;
                    if (a >= 32 && a < 40) m_sec[a-32] = wdata;
                end
            end
            m_s2_0 = m_s1_0; m_s2_1 = m_s1_1;
            m_s1_0 = gpio_in[0]; m_s1_1 = gpio_in[1];
            if (cpu_trap) m_trap = 1;
            m_cnt = m_cnt + 1;
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // compare against the model on every cycle, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [2:0] eled;
            eled = m_trap ? {m_cnt[BL], 2'b00} : m_led;
            chk("R11 rdata", rdata, m_rd);
            chk("R4_R10 led", {29'd0, led}, {29'd0, eled});
            chk("R5 gpio_out", {30'd0, gpio_out}, {30'd0, m_gpo});
            chk("R9 addr_key", addr_key, m_ak);
            chk("R9 data_key", data_key, m_dk);
            chk("R2_R3 app_mode", {31'd0, app_mode}, {31'd0, m_mode});
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk); cs = 1; we = 1; addr = AW'(a); wdata = d;
        @(negedge clk); cs = 0; we = 0;
    endtask

    task automatic rd(int a, logic [31:0] exp, string tag);
        @(negedge clk); cs = 1; we = 0; addr = AW'(a);
        @(negedge clk); cs = 0;
        chk(tag, rdata, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk("R12 led", {29'd0, led}, 32'd0);
        chk("R12 keys", addr_key | data_key, 32'd0);
        chk("R12 mode", {31'd0, app_mode}, 32'd0);
        chk("R12 rdata", rdata, 32'd0);
        rd(12, 32'd0, "R12 app_start");

        // R1 identity
        rd(0, N_HI, "R1 name hi");
        rd(1, N_LO, "R1 name lo");
        rd(2, VER,  "R1 version");
        wr(2, 32'hdead_beef);
        rd(2, VER,  "R1 version after write");

        // R4 LED
        wr(9, 32'h5);
        chk("R4 led pins", {29'd0, led}, 32'h5);
        rd(9, 32'h5, "R4 led readback");

        // R5 GPIO
        gpio_in = 2'b10;
        repeat (3) @(negedge clk);
        wr(10, 32'hf);
        chk("R5 gpio pins", {30'd0, gpio_out}, 32'h3);
        rd(10, 32'he, "R5 gpio readback");

        // R6 application words
        wr(12, 32'h0000_4000);
        wr(13, 32'h0000_1234);
        wr(16, 32'h0000_0abc);
        rd(12, 32'h0000_4000, "R6 start");
        rd(13, 32'h0000_1234, "R6 size");
        rd(16, 32'h0000_0abc, "R6 fnptr");

        // R7 secret hidden before switch
        for (int i = 0; i < 8; i++) wr(32 + i, 32'h1111_0000 + i);
        rd(32, 32'd0, "R7 secret hidden");

        // R9 keys
        wr(64, 32'haaaa_5555);
        wr(65, 32'h1234_8765);
        chk("R9 akey", addr_key, 32'haaaa_5555);
        chk("R9 dkey", data_key, 32'h1234_8765);
        rd(64, 32'd0, "R9 write-only read");

        // R8 identity constant
        wr(48, 32'hffff_ffff);
        rd(48, UIDV[31:0],  "R8 uid lo");
        rd(49, UIDV[63:32], "R8 uid hi");

        // R11 unmapped
        rd(127, 32'd0, "R11 unmapped");

        // R3 / R2 mode switch
        fw_mode = 0;
        wr(8, 32'h1);
        chk("R3 no switch outside fw", {31'd0, app_mode}, 32'd0);
        fw_mode = 1;
        wr(8, 32'h1);
        chk("R2 switch set", {31'd0, app_mode}, 32'd1);
        rd(8, 32'h1, "R2 mode readback");
        wr(8, 32'h0);
        chk("R3 sticky", {31'd0, app_mode}, 32'd1);
        fw_mode = 0;

        // locked behaviour
        wr(12, 32'h9999_9999);
        rd(12, 32'h0000_4000, "R6 locked start");
        wr(35, 32'h7777_7777);
        rd(35, 32'h1111_0003, "R7 secret after switch");
        rd(39, 32'h1111_0007, "R7 last secret word");
        wr(64, 32'h0);
        chk("R9 key locked", addr_key, 32'haaaa_5555);
        wr(9, 32'h3);
        rd(9, 32'h3, "R4 led in app mode");

        // R10 trap
        @(negedge clk); cpu_trap = 1;
        @(negedge clk); cpu_trap = 0;
        begin
            int toggles = 0;
            logic prev;
            prev = led[2];
            for (int k = 0; k < 64; k++) begin
                @(negedge clk);
                if (led[2] != prev) toggles++;
                prev = led[2];
                chk("R10 green blue off", {30'd0, led[1:0]}, 32'd0);
            end
            chk("R10 toggle count", {31'd0, (toggles >= 7 && toggles <= 8)}, 32'd1);
        end
        wr(9, 32'h7);
        chk("R10 override holds", {30'd0, led[1:0]}, 32'd0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule